// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block tracks in-flight instructions of an out-of-order core in a circular queue. The issue stage allocates one entry per cycle in program order and receives back the entry index, which becomes the tag for that instruction's result. Functional units later broadcast results by that index. Issue logic can read any entry's value and ready bit combinationally, so it can forward completed results that have not yet retired.

Retirement is strictly in order and happens at most once per cycle. A register-class instruction retires through a register-file write port, a store retires through a memory write port, and a branch simply frees its slot. Entries issued under an unresolved branch carry a speculative mark that blocks retirement. Resolving a branch as correct lifts that mark from every younger entry. A branch resolved as mispredicted drains all younger work and raises a redirect when it retires. A result tagged with a fault is reported only once its entry reaches the head without a speculative mark. The buffer is then emptied, which keeps exceptions precise.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, no entry reads ready on a lookup port, and no commit, write, redirect or exception output is active.
- R2: Each accepted allocation takes the index shown on `alloc_idx_o`, and the index advances by one modulo DEPTH. After DEPTH allocations with no retirement, `alloc_ready_o` is 0 and a further allocation request is ignored, so the next free index is unchanged.
- R3: A result write sets the tagged entry's value and ready bit. From the next cycle on, a lookup port addressed to that index returns the value with ready 1 in the same cycle as the index is applied.
- R4: Only the head entry may retire, and only when it is ready and not speculative. Younger ready entries wait, and at most one entry retires per cycle.
- R5: Retiring a register entry (kind code 2) raises `rf_we_o` with `rf_addr_o` equal to the low REG_W bits of the destination and `rf_data_o` equal to the stored value.
- R6: Retiring a store entry (kind code 1) raises `st_we_o` with the destination as address and the value as data. Retiring a correctly predicted branch (kind code 0) raises `commit_valid_o` and no write.
- R7: A ready entry with its speculative mark set never retires. A branch resolved as correctly predicted clears the speculative mark of every valid entry younger than it, including one allocated in the same cycle.
- R8: When a branch resolved as mispredicted retires, `redirect_o` is 1 together with `commit_valid_o`, no write is raised, and `alloc_ready_o` is 0 in that cycle. Every younger entry is discarded, and the next free index is the one just after the branch.
- R9: A result written with the fault flag raises `exc_o` with `exc_idx_o` equal to its index once that entry is at the head and not speculative. No write or commit is raised in that cycle, and the buffer is then empty with the next free index equal to the faulting index. The fault stays silent while the entry is speculative.
- R10: In any cycle at most one of `rf_we_o`, `st_we_o`, `redirect_o` and `exc_o` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_kind_i | input | 2 | 0 branch, 1 store, 2 register result |
| alloc_dest_i | input | ADDR_W | Register number or store address |
| alloc_spec_i | input | 1 | Issued under an unresolved branch |
| alloc_ready_o | output | 1 | A free entry can be taken this cycle |
| alloc_idx_o | output | log2(DEPTH) | Index given to the allocation |
| wb_valid_i | input | 1 | Result broadcast valid |
| wb_idx_i | input | log2(DEPTH) | Entry receiving the result |
| wb_value_i | input | DATA_W | Result value |
| wb_exc_i | input | 1 | Result carries a fault |
| br_valid_i | input | 1 | Branch resolution valid |
| br_idx_i | input | log2(DEPTH) | Entry of the resolved branch |
| br_mispred_i | input | 1 | Branch was mispredicted |
| lookup_idx_i | input | LOOKUP_N x log2(DEPTH) | Operand lookup indices |
| lookup_value_o | output | LOOKUP_N x DATA_W | Looked-up values |
| lookup_ready_o | output | LOOKUP_N | Looked-up entry is valid and ready |
| commit_valid_o | output | 1 | Head entry retires this cycle |
| commit_idx_o | output | log2(DEPTH) | Index of the retiring entry |
| rf_we_o | output | 1 | Register file write |
| rf_addr_o | output | REG_W | Register number |
| rf_data_o | output | DATA_W | Register data |
| st_we_o | output | 1 | Memory store |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| redirect_o | output | 1 | Mispredicted branch retires, fetch restarts |
| exc_o | output | 1 | Precise exception taken at the head |
| exc_idx_o | output | log2(DEPTH) | Index of the faulting entry |

## Verification
The checks assume that result writes and branch resolutions only address entries that are currently allocated. They also assume that branch resolutions only address entries allocated as branches, and that each entry receives at most one result or resolution. The stimulus keeps to this by writing results and resolutions only to indices returned by `alloc_idx_o` since the last flush, one per entry. It never issues a request at an index freed by a redirect or exception.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    OP_BRANCH = 2'd0,
    OP_STORE  = 2'd1,
    OP_REG    = 2'd2
  } op_kind_e;
endpackage

// File: rtl/spec_rob_ptrs.sv
module spec_rob_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     flush_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic [$clog2(DEPTH)-1:0] tail_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W:0] head_q, tail_q, head_nxt;

  assign head_nxt = head_q + {{PTR_W{1'b0}}, pop_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nxt;
      // flush: everything younger than the retiring head is dropped
      if (flush_i)     tail_q <= head_nxt;
      else if (push_i) tail_q <= tail_q + 1'b1;
    end
  end

  assign head_o  = head_q[PTR_W-1:0];
  assign tail_o  = tail_q[PTR_W-1:0];
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[PTR_W] != tail_q[PTR_W]) &&
                   (head_q[PTR_W-1:0] == tail_q[PTR_W-1:0]);
endmodule

// File: rtl/spec_rob_entries.sv
module spec_rob_entries #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(DEPTH)-1:0]      head_i,
  input  logic                          alloc_en_i,
  input  logic [$clog2(DEPTH)-1:0]      alloc_idx_i,
  input  logic [1:0]                    alloc_kind_i,
  input  logic [ADDR_W-1:0]             alloc_dest_i,
  input  logic                          alloc_spec_i,
  input  logic                          wb_en_i,
  input  logic [$clog2(DEPTH)-1:0]      wb_idx_i,
  input  logic [DATA_W-1:0]             wb_value_i,
  input  logic                          wb_exc_i,
  input  logic                          br_en_i,
  input  logic [$clog2(DEPTH)-1:0]      br_idx_i,
  input  logic                          br_mispred_i,
  input  logic                          retire_en_i,
  input  logic                          flush_i,
  output logic [DEPTH-1:0]              valid_o,
  output logic [DEPTH-1:0]              ready_o,
  output logic [DEPTH-1:0]              spec_o,
  output logic [DEPTH-1:0]              exc_o,
  output logic [DEPTH-1:0]              mispred_o,
  output logic [DEPTH-1:0][1:0]         kind_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  dest_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  value_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] br_age;
  assign br_age = br_idx_i - head_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              vld_q, rdy_q, spc_q, exc_q, msp_q;
    logic [1:0]        knd_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] val_q;
    logic [PTR_W-1:0]  age;
    logic              hit_alloc, hit_wb, hit_br, hit_ret, younger;

    assign age       = PTR_W'(i) - head_i;
    assign younger   = age > br_age;
    assign hit_alloc = alloc_en_i && (alloc_idx_i == PTR_W'(i));
    assign hit_wb    = wb_en_i && (wb_idx_i == PTR_W'(i)) && vld_q;
    assign hit_br    = br_en_i && (br_idx_i == PTR_W'(i)) && vld_q;
    assign hit_ret   = retire_en_i && (head_i == PTR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        rdy_q <= 1'b0;
        spc_q <= 1'b0;
        exc_q <= 1'b0;
        msp_q <= 1'b0;
        knd_q <= '0;
        dst_q <= '0;
        val_q <= '0;
      end else if (flush_i) begin
        vld_q <= 1'b0;
        rdy_q <= 1'b0;
      end else if (hit_alloc) begin
        vld_q <= 1'b1;
        rdy_q <= 1'b0;
        spc_q <= alloc_spec_i;
        exc_q <= 1'b0;
        msp_q <= 1'b0;
        knd_q <= alloc_kind_i;
        dst_q <= alloc_dest_i;
      end else begin
        if (hit_ret) vld_q <= 1'b0;
        if (hit_wb) begin
          val_q <= wb_value_i;
          rdy_q <= 1'b1;
          exc_q <= wb_exc_i;
        end
        if (hit_br) begin
          rdy_q <= 1'b1;
          msp_q <= br_mispred_i;
        end
        if (br_en_i && !br_mispred_i && younger) spc_q <= 1'b0;
      end
    end

    assign valid_o[i]   = vld_q;
    assign ready_o[i]   = rdy_q;
    assign spec_o[i]    = spc_q;
    assign exc_o[i]     = exc_q;
    assign mispred_o[i] = msp_q;
    assign kind_o[i]    = knd_q;
    assign dest_o[i]    = dst_q;
    assign value_o[i]   = val_q;
  end
endmodule

// File: rtl/spec_rob_retire.sv
module spec_rob_retire
  import spec_rob_pkg::*;
(
  input  logic       hd_valid_i,
  input  logic       hd_ready_i,
  input  logic       hd_spec_i,
  input  logic       hd_exc_i,
  input  logic       hd_mispred_i,
  input  logic [1:0] hd_kind_i,
  output logic       retire_o,
  output logic       rf_we_o,
  output logic       st_we_o,
  output logic       redirect_o,
  output logic       exc_take_o,
  output logic       flush_o
);
  logic can_go;

  assign can_go     = hd_valid_i && hd_ready_i && !hd_spec_i;
  assign exc_take_o = can_go && hd_exc_i;
  assign retire_o   = can_go && !hd_exc_i;
  assign rf_we_o    = retire_o && (hd_kind_i == OP_REG);
  assign st_we_o    = retire_o && (hd_kind_i == OP_STORE);
  assign redirect_o = retire_o && (hd_kind_i == OP_BRANCH) && hd_mispred_i;
  assign flush_o    = exc_take_o || redirect_o;
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int REG_W    = 5,
  parameter int LOOKUP_N = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   alloc_valid_i,
  input  logic [1:0]                             alloc_kind_i,
  input  logic [ADDR_W-1:0]                      alloc_dest_i,
  input  logic                                   alloc_spec_i,
  output logic                                   alloc_ready_o,
  output logic [$clog2(DEPTH)-1:0]               alloc_idx_o,
  input  logic                                   wb_valid_i,
  input  logic [$clog2(DEPTH)-1:0]               wb_idx_i,
  input  logic [DATA_W-1:0]                      wb_value_i,
  input  logic                                   wb_exc_i,
  input  logic                                   br_valid_i,
  input  logic [$clog2(DEPTH)-1:0]               br_idx_i,
  input  logic                                   br_mispred_i,
  input  logic [LOOKUP_N-1:0][$clog2(DEPTH)-1:0] lookup_idx_i,
  output logic [LOOKUP_N-1:0][DATA_W-1:0]        lookup_value_o,
  output logic [LOOKUP_N-1:0]                    lookup_ready_o,
  output logic                                   commit_valid_o,
  output logic [$clog2(DEPTH)-1:0]               commit_idx_o,
  output logic                                   rf_we_o,
  output logic [REG_W-1:0]                       rf_addr_o,
  output logic [DATA_W-1:0]                      rf_data_o,
  output logic                                   st_we_o,
  output logic [ADDR_W-1:0]                      st_addr_o,
  output logic [DATA_W-1:0]                      st_data_o,
  output logic                                   redirect_o,
  output logic                                   exc_o,
  output logic [$clog2(DEPTH)-1:0]               exc_idx_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]              head, tail;
  logic                          full, empty, flush, retire, alloc_en, alloc_spec_eff;
  logic [DEPTH-1:0]              ent_valid, ent_ready, ent_spec, ent_exc, ent_misp;
  logic [DEPTH-1:0][1:0]         ent_kind;
  logic [DEPTH-1:0][ADDR_W-1:0]  ent_dest;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_value;

  assign alloc_ready_o  = !full && !flush;
  assign alloc_en       = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o    = tail;
  // a correct resolution in the same cycle also covers the entry being allocated
  assign alloc_spec_eff = alloc_spec_i && !(br_valid_i && !br_mispred_i);

  spec_rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_en),
    .pop_i   (retire),
    .flush_i (flush),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full),
    .empty_o (empty)
  );

  spec_rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ents (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_i       (head),
    .alloc_en_i   (alloc_en),
    .alloc_idx_i  (tail),
    .alloc_kind_i (alloc_kind_i),
    .alloc_dest_i (alloc_dest_i),
    .alloc_spec_i (alloc_spec_eff),
    .wb_en_i      (wb_valid_i),
    .wb_idx_i     (wb_idx_i),
    .wb_value_i   (wb_value_i),
    .wb_exc_i     (wb_exc_i),
    .br_en_i      (br_valid_i),
    .br_idx_i     (br_idx_i),
    .br_mispred_i (br_mispred_i),
    .retire_en_i  (retire),
    .flush_i      (flush),
    .valid_o      (ent_valid),
    .ready_o      (ent_ready),
    .spec_o       (ent_spec),
    .exc_o        (ent_exc),
    .mispred_o    (ent_misp),
    .kind_o       (ent_kind),
    .dest_o       (ent_dest),
    .value_o      (ent_value)
  );

  spec_rob_retire u_ret (
    .hd_valid_i   (ent_valid[head]),
    .hd_ready_i   (ent_ready[head]),
    .hd_spec_i    (ent_spec[head]),
    .hd_exc_i     (ent_exc[head]),
    .hd_mispred_i (ent_misp[head]),
    .hd_kind_i    (ent_kind[head]),
    .retire_o     (retire),
    .rf_we_o      (rf_we_o),
    .st_we_o      (st_we_o),
    .redirect_o   (redirect_o),
    .exc_take_o   (exc_o),
    .flush_o      (flush)
  );

  assign commit_valid_o = retire;
  assign commit_idx_o   = head;
  assign exc_idx_o      = head;
  assign rf_addr_o      = ent_dest[head][REG_W-1:0];
  assign rf_data_o      = ent_value[head];
  assign st_addr_o      = ent_dest[head];
  assign st_data_o      = ent_value[head];

  for (genvar p = 0; p < LOOKUP_N; p++) begin : g_lookup
    assign lookup_value_o[p] = ent_value[lookup_idx_i[p]];
    assign lookup_ready_o[p] = ent_valid[lookup_idx_i[p]] && ent_ready[lookup_idx_i[p]];
  end
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     full,
  input logic                     empty,
  input logic                     flush,
  input logic                     alloc_ready_o,
  input logic                     rf_we_o,
  input logic                     st_we_o,
  input logic                     redirect_o,
  input logic                     exc_o,
  input logic                     wb_valid_i,
  input logic [$clog2(DEPTH)-1:0] wb_idx_i,
  input logic [DEPTH-1:0]         ent_valid,
  input logic [DEPTH-1:0]         ent_ready
);
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !alloc_ready_o);

  // R10
  single_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, st_we_o, redirect_o, exc_o}));

  // R8
  redirect_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> empty);

  // R9
  exc_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> empty);

  // R3
  wb_sets_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && ent_valid[wb_idx_i] && !flush) |=> ent_ready[$past(wb_idx_i)]);
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .full          (full),
  .empty         (empty),
  .flush         (flush),
  .alloc_ready_o (alloc_ready_o),
  .rf_we_o       (rf_we_o),
  .st_we_o       (st_we_o),
  .redirect_o    (redirect_o),
  .exc_o         (exc_o),
  .wb_valid_i    (wb_valid_i),
  .wb_idx_i      (wb_idx_i),
  .ent_valid     (ent_valid),
  .ent_ready     (ent_ready)
);

// File: tb/tb_spec_rob.sv
module tb_spec_rob;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic        st;
    logic [31:0] dest;
    logic [31:0] val;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd3,      32'h0000_00A0},
    '{1'b1, 32'h0000_1000, 32'h0000_00B1},
    '{1'b0, 32'd17,     32'h0000_00C2},
    '{1'b0, 32'd31,     32'hDEAD_BEEF},
    '{1'b1, 32'h0000_2004, 32'h1234_5678},
    '{1'b0, 32'd1,      32'h0000_00F5}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              alloc_valid = 1'b0;
  logic [1:0]        alloc_kind = '0;
  logic [31:0]       alloc_dest = '0;
  logic              alloc_spec = 1'b0;
  logic              alloc_ready;
  logic [2:0]        alloc_idx;
  logic              wb_valid = 1'b0;
  logic [2:0]        wb_idx = '0;
  logic [31:0]       wb_value = '0;
  logic              wb_exc = 1'b0;
  logic              br_valid = 1'b0;
  logic [2:0]        br_idx = '0;
  logic              br_mispred = 1'b0;
  logic [1:0][2:0]   lookup_idx = '0;
  logic [1:0][31:0]  lookup_value;
  logic [1:0]        lookup_ready;
  logic              commit_valid;
  logic [2:0]        commit_idx;
  logic              rf_we;
  logic [4:0]        rf_addr;
  logic [31:0]       rf_data;
  logic              st_we;
  logic [31:0]       st_addr;
  logic [31:0]       st_data;
  logic              redirect;
  logic              exc;
  logic [2:0]        exc_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_rob dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_kind_i(alloc_kind), .alloc_dest_i(alloc_dest),
    .alloc_spec_i(alloc_spec), .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_value_i(wb_value), .wb_exc_i(wb_exc),
    .br_valid_i(br_valid), .br_idx_i(br_idx), .br_mispred_i(br_mispred),
    .lookup_idx_i(lookup_idx), .lookup_value_o(lookup_value), .lookup_ready_o(lookup_ready),
    .commit_valid_o(commit_valid), .commit_idx_o(commit_idx),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_data_o(rf_data),
    .st_we_o(st_we), .st_addr_o(st_addr), .st_data_o(st_data),
    .redirect_o(redirect), .exc_o(exc), .exc_idx_o(exc_idx)
  );

  task automatic check_eq(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // wait for an edge, then drop all strobes and let outputs settle
  task automatic tick();
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
    wb_valid    = 1'b0;
    br_valid    = 1'b0;
    #1;
  endtask

  task automatic do_alloc(input logic [1:0] kind, input logic [31:0] dest, input logic spec,
                          input int exp_idx);
    alloc_valid = 1'b1;
    alloc_kind  = kind;
    alloc_dest  = dest;
    alloc_spec  = spec;
    #1;
    check_eq("R2 alloc_idx", 64'(alloc_idx), 64'(exp_idx));
    tick();
  endtask

  task automatic do_wb(input int idx, input logic [31:0] val, input logic fault);
    wb_valid = 1'b1;
    wb_idx   = 3'(idx);
    wb_value = val;
    wb_exc   = fault;
    tick();
  endtask

  task automatic do_br(input int idx, input logic mis);
    br_valid   = 1'b1;
    br_idx     = 3'(idx);
    br_mispred = mis;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    check_eq("R1 alloc_ready", 64'(alloc_ready), 64'd1);
    check_eq("R1 alloc_idx", 64'(alloc_idx), 64'd0);
    check_eq("R1 lookup_ready", 64'(lookup_ready), 64'd0);
    check_eq("R1 outputs idle", 64'({commit_valid, rf_we, st_we, redirect, exc}), 64'd0);

    // table: allocate in order, complete in reverse, retire in order
    for (int i = 0; i < NV; i++)
      do_alloc(VECS[i].st ? 2'd1 : 2'd2, VECS[i].dest, 1'b0, i);
    lookup_idx[0] = 3'd0;
    #1 check_eq("R3 lookup before write", 64'(lookup_ready[0]), 64'd0);
    for (int i = NV - 1; i >= 1; i--) begin
      do_wb(i, VECS[i].val, 1'b0);
      check_eq("R4 head not ready blocks", 64'(commit_valid), 64'd0);
    end
    lookup_idx[1] = 3'd5;
    #1;
    check_eq("R3 lookup ready", 64'(lookup_ready[1]), 64'd1);
    check_eq("R3 lookup value", 64'(lookup_value[1]), 64'(VECS[5].val));
    do_wb(0, VECS[0].val, 1'b0);
    for (int i = 0; i < NV; i++) begin
      check_eq("R4 commit_valid", 64'(commit_valid), 64'd1);
      check_eq("R4 commit_idx", 64'(commit_idx), 64'(i));
      if (VECS[i].st) begin
        check_eq("R6 st_we", 64'(st_we), 64'd1);
        check_eq("R6 st_addr", 64'(st_addr), 64'(VECS[i].dest));
        check_eq("R6 st_data", 64'(st_data), 64'(VECS[i].val));
        check_eq("R10 rf_we off", 64'(rf_we), 64'd0);
      end else begin
        check_eq("R5 rf_we", 64'(rf_we), 64'd1);
        check_eq("R5 rf_addr", 64'(rf_addr), 64'(VECS[i].dest[4:0]));
        check_eq("R5 rf_data", 64'(rf_data), 64'(VECS[i].val));
        check_eq("R10 st_we off", 64'(st_we), 64'd0);
      end
      tick();
    end
    check_eq("R4 drained", 64'(commit_valid), 64'd0);
    check_eq("R2 next idx", 64'(alloc_idx), 64'd6);

    // fill to capacity, then try one more
    for (int k = 0; k < 8; k++) do_alloc(2'd2, 32'(k), 1'b0, (6 + k) % 8);
    check_eq("R2 full no ready", 64'(alloc_ready), 64'd0);
    alloc_valid = 1'b1;
    alloc_kind  = 2'd2;
    tick();
    check_eq("R2 full ignores alloc", 64'(alloc_idx), 64'd6);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      wb_valid = 1'b1;
      wb_idx   = 3'((6 + k) % 8);
      wb_value = 32'(k);
      wb_exc   = 1'b0;
      #1 cnt += int'(commit_valid);
      tick();
    end
    for (int k = 0; k < 10; k++) begin
      cnt += int'(commit_valid);
      tick();
    end
    check_eq("R4 one retire per entry", 64'(cnt), 64'd8);
    check_eq("R2 idx after drain", 64'(alloc_idx), 64'd6);

    // correct branches unlock younger speculative work
    do_alloc(2'd0, 32'd0, 1'b0, 6);
    do_alloc(2'd0, 32'd0, 1'b1, 7);
    do_alloc(2'd2, 32'd9, 1'b1, 0);
    do_wb(0, 32'h55, 1'b0);
    do_br(7, 1'b0);
    check_eq("R4 unresolved head blocks", 64'(commit_valid), 64'd0);
    tick();
    check_eq("R4 still blocked", 64'(commit_valid), 64'd0);
    do_br(6, 1'b0);
    check_eq("R6 branch commit", 64'(commit_valid), 64'd1);
    check_eq("R6 branch no write", 64'({rf_we, st_we, redirect}), 64'd0);
    tick();
    check_eq("R7 inner branch unblocked", 64'(commit_valid), 64'd1);
    check_eq("R7 inner branch idx", 64'(commit_idx), 64'd7);
    tick();
    check_eq("R7 spec cleared rf_we", 64'(rf_we), 64'd1);
    check_eq("R7 spec cleared data", 64'(rf_data), 64'h55);
    tick();
    check_eq("R2 idx after branches", 64'(alloc_idx), 64'd1);

    // mispredicted branch
    do_alloc(2'd0, 32'd0, 1'b0, 1);
    do_alloc(2'd2, 32'd3, 1'b1, 2);
    do_alloc(2'd1, 32'h100, 1'b1, 3);
    do_wb(2, 32'h11, 1'b0);
    do_wb(3, 32'h22, 1'b0);
    check_eq("R7 speculative ready waits", 64'(commit_valid), 64'd0);
    do_br(1, 1'b1);
    check_eq("R8 redirect", 64'(redirect), 64'd1);
    check_eq("R8 commit_valid", 64'(commit_valid), 64'd1);
    check_eq("R8 no write", 64'({rf_we, st_we}), 64'd0);
    check_eq("R8 alloc blocked", 64'(alloc_ready), 64'd0);
    tick();
    lookup_idx[1] = 3'd2;
    #1;
    check_eq("R8 redirect pulse", 64'(redirect), 64'd0);
    check_eq("R8 younger gone", 64'(commit_valid), 64'd0);
    check_eq("R8 lookup discarded", 64'(lookup_ready[1]), 64'd0);
    check_eq("R8 next idx", 64'(alloc_idx), 64'd2);
    check_eq("R8 alloc ready", 64'(alloc_ready), 64'd1);

    // precise exception
    do_alloc(2'd2, 32'd4, 1'b0, 2);
    do_alloc(2'd2, 32'd5, 1'b0, 3);
    do_wb(3, 32'h33, 1'b0);
    do_wb(2, 32'h44, 1'b1);
    check_eq("R9 exc", 64'(exc), 64'd1);
    check_eq("R9 exc_idx", 64'(exc_idx), 64'd2);
    check_eq("R9 no commit", 64'({commit_valid, rf_we, st_we}), 64'd0);
    tick();
    lookup_idx[1] = 3'd3;
    #1;
    check_eq("R9 exc pulse", 64'(exc), 64'd0);
    check_eq("R9 next idx", 64'(alloc_idx), 64'd2);
    check_eq("R9 younger gone", 64'(lookup_ready[1]), 64'd0);

    // speculative head never retires, fault stays silent
    do_alloc(2'd2, 32'd6, 1'b1, 2);
    do_wb(2, 32'h66, 1'b1);
    lookup_idx[0] = 3'd2;
    #1;
    check_eq("R3 lookup spec value", 64'(lookup_value[0]), 64'h66);
    check_eq("R9 spec fault silent", 64'(exc), 64'd0);
    check_eq("R7 spec head blocked", 64'(commit_valid), 64'd0);
    tick();
    tick();
    check_eq("R7 spec head still blocked", 64'({commit_valid, exc}), 64'd0);

    // reset mid-run
    rst_ni = 1'b0;
    #2;
    check_eq("R1 reset idx", 64'(alloc_idx), 64'd0);
    check_eq("R1 reset lookup", 64'(lookup_ready[0]), 64'd0);
    tick();
    rst_ni = 1'b1;
    #1;
    check_eq("R1 reset ready", 64'(alloc_ready), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule